// File: doc/BRIEF.md
# Virtual Function Capability Register Block

This block holds the configuration-space state through which system software sets up the virtual functions of a physical function. It sits at a fixed DWORD-aligned base inside configuration space. It accepts DWORD reads and byte-enabled DWORD writes, and it answers only inside its own 64-byte window.

From that state it drives one enable line per virtual function, together with a count of the virtual functions that are active. The enable lines follow the control register directly. Writes to some fields also change other fields:

- Setting the enable bit is refused when the requested count exceeds the number the function supports.
- Any write that reaches the count field turns every virtual function off.

Reads return data one cycle after the read strobe. The capability header DWORDs and the BAR array of the window read as zero in this block.

Top module: `sriov_cap_block`

## Requirements
- R1: Reset, synchronous and active low on `rstN`, clears the control field and the requested VF count to 0 and sets the system page size to 0x1. All `vfEnable` lines and `activeVfCount` are then 0.
- R2: The control field is bits 15:0 of window DWORD 2. Only bit 0 (VF enable), bit 3 (VF memory space enable) and bit 4 (ARI hierarchy) can be written. Every other bit of that DWORD reads 0.
- R3: These fields are read-only and take their values from parameters: DWORD 3 = {total VFs, initial VFs}, DWORD 5 = {VF stride, first VF offset}, and DWORD 6 bits 31:16 = VF device ID. Writes to them change nothing.
- R4: The requested VF count is bits 15:0 of DWORD 4 and all 16 bits can be written. Bits 31:16 of DWORD 4 read 0.
- R5: DWORD 7 (supported page sizes) reads 0x553 OR the `OPT_PGSIZE` parameter and cannot be written. DWORD 8 (system page size) can be written only in those same bit positions.
- R6: A write that sets VF enable while the requested count N is at most the total makes `vfEnable[N-1:0]` high and sets `activeVfCount` to N. Both are visible in the cycle after the write.
- R7: A write that sets VF enable while N exceeds the total leaves VF enable reading 0, and no `vfEnable` line rises.
- R8: A control write that leaves VF enable at 0 drops every `vfEnable` line and sets `activeVfCount` to 0.
- R9: A write with byte lane 0 or byte lane 1 enabled on DWORD 4 clears VF enable and drops every VF. A write to DWORD 4 using only lanes 2 and 3 has no such effect.
- R10: A write whose DWORD address lies below the base or at or beyond base+16 DWORDs changes no state. A read there returns 0.
- R11: Only the bytes whose `byteEn` bit is set are updated. Lane k covers data bits 8k+7:8k.
- R12: `rdValid` is high exactly in the cycle after `rdEn`, and `rdData` carries the addressed DWORD in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| dwAddr | input | ADDR_W-2 | Configuration-space DWORD address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| byteEn | input | 4 | Byte lane enables for writes |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| vfEnable | output | TOTAL_VFS | Per-VF enable lines |
| activeVfCount | output | 16 | Number of enabled VFs |

## Verification
The bench sets VF enable with the requested count set to exactly the total and to one above it. A design that compares with the wrong inequality either refuses the legal maximum or turns on more lines than exist.

The bench also writes the count DWORD through the upper lanes only and through the lower lanes only. A decoder that ignores the byte enables would drop the VFs when they should stay on, or keep them on when they should drop.

Writes just below the window and in an aliased location above it expose an incomplete range check, which would let such writes corrupt the count. Writing all ones to the control, page-size and read-only DWORDs exposes any bit that a wrong write mask lets through.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;

  // DWORD indices inside the capability window
  localparam logic [3:0] DW_CTRL   = 4'd2;
  localparam logic [3:0] DW_COUNTS = 4'd3;
  localparam logic [3:0] DW_NUMVF  = 4'd4;
  localparam logic [3:0] DW_ROUTE  = 4'd5;
  localparam logic [3:0] DW_DEVID  = 4'd6;
  localparam logic [3:0] DW_SUPPG  = 4'd7;
  localparam logic [3:0] DW_SYSPG  = 4'd8;

  localparam int WINDOW_DWORDS = 16;

  // control field bits
  localparam int BIT_VF_EN  = 0;
  localparam int BIT_VF_MSE = 3;
  localparam int BIT_ARI    = 4;

  localparam logic [31:0] CTRL_WMASK  = 32'h0000_0019;
  localparam logic [31:0] NUMVF_WMASK = 32'h0000_FFFF;
  localparam logic [15:0] PG_MIN_SET  = 16'h0553;
  localparam logic [31:0] SYSPG_RESET = 32'h0000_0001;

  typedef struct packed {
    logic       inWindow;
    logic [3:0] dwIdx;
    logic [3:0] laneEn;
    logic       ctrlTouch;
    logic       numVfTouch;
    logic       sysPgTouch;
    logic       rdStb;
  } accStrobes_t;

  function automatic logic [31:0] mergeLanes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [3:0]  lanes,
                                             input logic [31:0] wmask);
    logic [31:0] res;
    res = oldVal;
    for (int k = 0; k < 4; k++) begin
      if (lanes[k]) begin
        res[8*k +: 8] = (oldVal[8*k +: 8] & ~wmask[8*k +: 8]) |
                        (newVal[8*k +: 8] &  wmask[8*k +: 8]);
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/sriov_cap_decode.sv
module sriov_cap_decode
  import sriov_cap_pkg::*;
#(
  parameter int CAP_BASE = 'h160,
  parameter int ADDR_W   = 12,
  localparam int DW_W    = ADDR_W - 2,
  localparam int BASE_DW = CAP_BASE / 4
) (
  input  logic [DW_W-1:0] dwAddr,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [3:0]      byteEn,
  output accStrobes_t     stb
);

  logic [DW_W-1:0] relDw;
  logic            aboveBase;
  logic            inWin;
  logic            lowLanes;
  logic            wrHit;

  assign relDw     = dwAddr - DW_W'(BASE_DW);
  assign aboveBase = (dwAddr >= DW_W'(BASE_DW));
  assign inWin     = aboveBase && (relDw[DW_W-1:4] == '0);
  assign lowLanes  = |byteEn[1:0];
  assign wrHit     = wrEn && inWin && (|byteEn);

  always_comb begin
    stb            = '0;
    stb.inWindow   = inWin;
    stb.dwIdx      = relDw[3:0];
    stb.laneEn     = byteEn;
    stb.rdStb      = rdEn;
    stb.ctrlTouch  = wrHit && (relDw[3:0] == DW_CTRL)  && lowLanes;
    stb.numVfTouch = wrHit && (relDw[3:0] == DW_NUMVF) && lowLanes;
    stb.sysPgTouch = wrHit && (relDw[3:0] == DW_SYSPG);
  end

endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
  import sriov_cap_pkg::*;
#(
  parameter int          TOTAL_VFS    = 8,
  parameter int          INITIAL_VFS  = 8,
  parameter int          VF_OFFSET    = 1,
  parameter int          VF_STRIDE    = 1,
  parameter logic [15:0] VF_DEVICE_ID = 16'hA0F1,
  parameter logic [15:0] OPT_PGSIZE   = 16'h0008,
  localparam logic [31:0] PG_MASK     = {16'h0, PG_MIN_SET | OPT_PGSIZE}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  accStrobes_t          stb,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic                 rdValid,
  output logic [TOTAL_VFS-1:0] vfEnable,
  output logic [15:0]          activeVfCount
);

  logic [31:0] ctrlReg, ctrlNext;
  logic [31:0] numVfReg, numVfNext;
  logic [31:0] sysPgReg, sysPgNext;
  logic [31:0] ctrlMerged;
  logic [31:0] readMux;
  logic        countTooBig;

  assign countTooBig = (numVfReg[15:0] > 16'(TOTAL_VFS));
  assign ctrlMerged  = mergeLanes(ctrlReg, wrData, stb.laneEn, CTRL_WMASK);

  // side effects: a control write wins over a count write
  always_comb begin
    ctrlNext  = ctrlReg;
    numVfNext = numVfReg;
    sysPgNext = sysPgReg;
    if (stb.ctrlTouch) begin
      ctrlNext = ctrlMerged;
      if (ctrlMerged[BIT_VF_EN] && countTooBig) begin
        ctrlNext[BIT_VF_EN] = 1'b0;
      end
    end else if (stb.numVfTouch) begin
      numVfNext           = mergeLanes(numVfReg, wrData, stb.laneEn, NUMVF_WMASK);
      ctrlNext[BIT_VF_EN] = 1'b0;
    end
    if (stb.sysPgTouch) begin
      sysPgNext = mergeLanes(sysPgReg, wrData, stb.laneEn, PG_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      numVfReg <= '0;
      sysPgReg <= SYSPG_RESET;
    end else begin
      ctrlReg  <= ctrlNext;
      numVfReg <= numVfNext;
      sysPgReg <= sysPgNext;
    end
  end

  always_comb begin
    readMux = '0;
    if (stb.inWindow) begin
      unique case (stb.dwIdx)
        DW_CTRL:   readMux = ctrlReg;
        DW_COUNTS: readMux = {16'(TOTAL_VFS), 16'(INITIAL_VFS)};
        DW_NUMVF:  readMux = numVfReg;
        DW_ROUTE:  readMux = {16'(VF_STRIDE), 16'(VF_OFFSET)};
        DW_DEVID:  readMux = {VF_DEVICE_ID, 16'h0};
        DW_SUPPG:  readMux = PG_MASK;
        DW_SYSPG:  readMux = sysPgReg;
        default:   readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdStb;
      if (stb.rdStb) rdData <= readMux;
    end
  end

  // one enable line per VF, thermometer coded from the count
  for (genvar i = 0; i < TOTAL_VFS; i++) begin : g_vfEn
    assign vfEnable[i] = ctrlReg[BIT_VF_EN] && (numVfReg[15:0] > 16'(i));
  end

  assign activeVfCount = ctrlReg[BIT_VF_EN] ? numVfReg[15:0] : 16'h0;

endmodule

// File: rtl/sriov_cap_block.sv
module sriov_cap_block
  import sriov_cap_pkg::*;
#(
  parameter int          CAP_BASE     = 'h160,
  parameter int          ADDR_W       = 12,
  parameter int          TOTAL_VFS    = 8,
  parameter int          INITIAL_VFS  = 8,
  parameter int          VF_OFFSET    = 1,
  parameter int          VF_STRIDE    = 1,
  parameter logic [15:0] VF_DEVICE_ID = 16'hA0F1,
  parameter logic [15:0] OPT_PGSIZE   = 16'h0008
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-3:0]    dwAddr,
  input  logic                 wrEn,
  input  logic [31:0]          wrData,
  input  logic [3:0]           byteEn,
  input  logic                 rdEn,
  output logic [31:0]          rdData,
  output logic                 rdValid,
  output logic [TOTAL_VFS-1:0] vfEnable,
  output logic [15:0]          activeVfCount
);

  accStrobes_t stb;

  sriov_cap_decode #(
    .CAP_BASE(CAP_BASE),
    .ADDR_W  (ADDR_W)
  ) uDecode (
    .dwAddr(dwAddr),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .byteEn(byteEn),
    .stb   (stb)
  );

  sriov_cap_regs #(
    .TOTAL_VFS   (TOTAL_VFS),
    .INITIAL_VFS (INITIAL_VFS),
    .VF_OFFSET   (VF_OFFSET),
    .VF_STRIDE   (VF_STRIDE),
    .VF_DEVICE_ID(VF_DEVICE_ID),
    .OPT_PGSIZE  (OPT_PGSIZE)
  ) uRegs (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (wrData),
    .rdData       (rdData),
    .rdValid      (rdValid),
    .vfEnable     (vfEnable),
    .activeVfCount(activeVfCount)
  );

endmodule

// File: rtl/sriov_cap_checker.sv
module sriov_cap_checker #(
  parameter int CAP_BASE  = 'h160,
  parameter int ADDR_W    = 12,
  parameter int TOTAL_VFS = 8,
  localparam int DW_W     = ADDR_W - 2,
  localparam int BASE_DW  = CAP_BASE / 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [DW_W-1:0]      dwAddr,
  input logic                 wrEn,
  input logic [31:0]          wrData,
  input logic [3:0]           byteEn,
  input logic                 rdEn,
  input logic [31:0]          rdData,
  input logic                 rdValid,
  input logic [TOTAL_VFS-1:0] vfEnable,
  input logic [15:0]          activeVfCount
);

  logic outside;
  logic ctrlLow;
  logic countLow;

  assign outside  = (dwAddr < DW_W'(BASE_DW)) || (dwAddr >= DW_W'(BASE_DW + 16));
  assign ctrlLow  = wrEn && (dwAddr == DW_W'(BASE_DW + 2)) && byteEn[0];
  assign countLow = wrEn && (dwAddr == DW_W'(BASE_DW + 4)) && (|byteEn[1:0]);

  AST_COUNT_MATCHES_LINES: assert property (@(posedge clk) disable iff (!rstN)
    $countones(vfEnable) == int'(activeVfCount)); // R6

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    activeVfCount <= 16'(TOTAL_VFS)); // R7

  AST_CLEAR_DROPS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlLow && !wrData[0]) |=> (vfEnable == '0)); // R8

  AST_COUNT_WRITE_DROPS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    countLow |=> (activeVfCount == 16'h0)); // R9

  AST_OUTSIDE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && outside) |=> $stable(vfEnable)); // R10

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R12

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid); // R12

endmodule

bind sriov_cap_block sriov_cap_checker #(
  .CAP_BASE (CAP_BASE),
  .ADDR_W   (ADDR_W),
  .TOTAL_VFS(TOTAL_VFS)
) uChk (.*);

// File: tb/sim_sriov_cap_block.sv
module sim_sriov_cap_block;

  localparam int CAP_BASE = 'h160;
  localparam int BASE_DW  = CAP_BASE / 4;
  localparam int NVF      = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  dwAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0]  byteEn = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        rdValid;
  logic [NVF-1:0] vfEnable;
  logic [15:0] activeVfCount;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  sriov_cap_block #(.CAP_BASE(CAP_BASE), .TOTAL_VFS(NVF)) u0 (
    .clk(clk), .rstN(rstN), .dwAddr(dwAddr), .wrEn(wrEn), .wrData(wrData),
    .byteEn(byteEn), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .vfEnable(vfEnable), .activeVfCount(activeVfCount)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R12: unexpected read data actual=%h expected=none", rdData);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (rdData !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  task automatic wr(input int dw, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    dwAddr = 10'(dw); wrData = d; byteEn = be; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; byteEn = '0;
  endtask

  task automatic rd(input int dw, input logic [31:0] e, input string tag);
    @(negedge clk);
    dwAddr = 10'(dw); rdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
    total++;
    if (rdValid !== 1'b1) begin
      bad++;
      $display("FAIL R12: rdValid actual=%b expected=1", rdValid);
    end
  endtask

  task automatic chkVf(input logic [NVF-1:0] m, input int n, input string tag);
    total++;
    if (vfEnable !== m || activeVfCount !== 16'(n)) begin
      bad++;
      $display("FAIL %s: actual=%h/%0d expected=%h/%0d", tag, vfEnable,
               activeVfCount, m, n);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkVf('0, 0, "R1 vf lines after reset");
    rd(BASE_DW + 2, 32'h0, "R1 control after reset");
    rd(BASE_DW + 4, 32'h0, "R1 count after reset");
    rd(BASE_DW + 8, 32'h1, "R1 page size after reset");
    // R3 read-only fields
    rd(BASE_DW + 3, 32'h0008_0008, "R3 counts");
    rd(BASE_DW + 5, 32'h0001_0001, "R3 offset stride");
    rd(BASE_DW + 6, 32'hA0F1_0000, "R3 device id");
    wr(BASE_DW + 3, 32'hFFFF_FFFF, 4'hF);
    wr(BASE_DW + 5, 32'hFFFF_FFFF, 4'hF);
    wr(BASE_DW + 6, 32'hFFFF_FFFF, 4'hF);
    rd(BASE_DW + 3, 32'h0008_0008, "R3 counts after write");
    rd(BASE_DW + 5, 32'h0001_0001, "R3 offset stride after write");
    rd(BASE_DW + 6, 32'hA0F1_0000, "R3 device id after write");
    // R5 supported page sizes
    rd(BASE_DW + 7, 32'h0000_055B, "R5 supported sizes");
    wr(BASE_DW + 7, 32'h0, 4'hF);
    rd(BASE_DW + 7, 32'h0000_055B, "R5 supported sizes after write");
    // R4 count fully writable, upper half zero
    wr(BASE_DW + 4, 32'hFFFF_0005, 4'hF);
    rd(BASE_DW + 4, 32'h0000_0005, "R4 count readback");
    // R2 / R6 enable with all control bits written
    wr(BASE_DW + 2, 32'hFFFF_FFFF, 4'hF);
    chkVf(8'h1F, 5, "R6 five VFs on");
    rd(BASE_DW + 2, 32'h0000_0019, "R2 control mask");
    // R8 clear enable
    wr(BASE_DW + 2, 32'h0000_0018, 4'hF);
    chkVf('0, 0, "R8 all VFs off");
    rd(BASE_DW + 2, 32'h0000_0018, "R8 control readback");
    // R9 upper lanes only: no side effect
    wr(BASE_DW + 2, 32'h0000_0001, 4'hF);
    chkVf(8'h1F, 5, "R6 re-enabled");
    wr(BASE_DW + 4, 32'h0000_0000, 4'b1100);
    chkVf(8'h1F, 5, "R9 upper lanes keep VFs");
    // R9 / R11 low lane write
    wr(BASE_DW + 4, 32'hAAAA_AA03, 4'b0001);
    chkVf('0, 0, "R9 count write drops VFs");
    rd(BASE_DW + 2, 32'h0000_0000, "R9 enable bit cleared");
    rd(BASE_DW + 4, 32'h0000_0003, "R11 low byte only");
    // R7 count above total
    wr(BASE_DW + 4, 32'h0000_0009, 4'hF);
    wr(BASE_DW + 2, 32'h0000_0001, 4'hF);
    chkVf('0, 0, "R7 enable refused");
    rd(BASE_DW + 2, 32'h0000_0000, "R7 enable reads zero");
    // R6 boundary: count equals total
    wr(BASE_DW + 4, 32'h0000_0008, 4'hF);
    wr(BASE_DW + 2, 32'h0000_0001, 4'hF);
    chkVf(8'hFF, 8, "R6 all eight VFs on");
    // R10 outside the window
    wr(BASE_DW - 1, 32'h0, 4'hF);
    wr(BASE_DW + 16 + 4, 32'h0, 4'hF);
    wr(BASE_DW + 16 + 2, 32'h0, 4'hF);
    chkVf(8'hFF, 8, "R10 outside writes ignored");
    rd(BASE_DW + 16 + 4, 32'h0, "R10 outside read zero");
    rd(BASE_DW + 4, 32'h0000_0008, "R10 count unchanged");
    // R11 second lane only
    wr(BASE_DW + 4, 32'h0000_0100, 4'b0010);
    rd(BASE_DW + 4, 32'h0000_0108, "R11 lane 1 only");
    chkVf('0, 0, "R9 lane 1 drops VFs");
    // R5 system page size mask
    wr(BASE_DW + 8, 32'hFFFF_FFFF, 4'hF);
    rd(BASE_DW + 8, 32'h0000_055B, "R5 system page mask");
    wr(BASE_DW + 8, 32'h0000_0002, 4'hF);
    rd(BASE_DW + 8, 32'h0000_0002, "R5 system page write");
    // R1 reset mid-run
    wr(BASE_DW + 4, 32'h0000_0002, 4'hF);
    wr(BASE_DW + 2, 32'h0000_0019, 4'hF);
    chkVf(8'h03, 2, "R6 two VFs on");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chkVf('0, 0, "R1 VFs off after reset");
    rd(BASE_DW + 2, 32'h0, "R1 control after second reset");
    rd(BASE_DW + 4, 32'h0, "R1 count after second reset");
    rd(BASE_DW + 8, 32'h1, "R1 page size after second reset");
    repeat (3) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R12: pending reads actual=%0d expected=0", expQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule